// File: doc/BRIEF.md
# Spin-Then-Swap Lock Acquirer with Growing Backoff

This block acquires a shared hardware lock word for one client and later frees it. A one-cycle acquire request starts a polling loop. The loop sends plain reads of the lock word to an atomic memory unit and keeps sending them while the word reads non-zero. When a read comes back zero, the block sends a single atomic test-and-set. A zero from the test-and-set means the client now owns the lock. A non-zero result means another requester got there first. The block then stays off the memory port for a waiting period and goes back to reading. Each failed test-and-set doubles the waiting period, up to a fixed ceiling. The period returns to its floor after every successful acquire.

The client learns of ownership from a one-cycle `acquired` pulse and from the level `lock_held`. A one-cycle release request sends a write of zero to the lock word. The block reports completion with a `released` pulse. A release request made while the lock is not owned changes nothing and raises `rel_err` for one cycle. The memory unit takes a request in the cycle it is presented. It returns exactly one response on `rsp_valid`, at least one cycle later. The block never has more than one request outstanding.

The controller is a state machine with six states: IDLE, READ (poll), TAS (atomic attempt), BACKOFF (wait), HELD and RELEASE (write zero). Its transitions are:
- IDLE→READ on an acquire request.
- READ→READ on a non-zero read.
- READ→TAS on a zero read.
- TAS→HELD on a zero result.
- TAS→BACKOFF on a non-zero result.
- BACKOFF→READ when the waiting period ends.
- HELD→RELEASE on a release request.
- RELEASE→IDLE on the write response.

Top module: `tts_lock_engine`

## Requirements
- R1: After reset the block is in IDLE. `req_valid`, `acquired`, `released`, `rel_err` and `lock_held` are all low.
- R2: While a read (op code 2'b00) returns a non-zero word, the next request is another read. No test-and-set (op code 2'b01) is issued.
- R3: A read that returns zero is followed by exactly one test-and-set request.
- R4: A test-and-set that returns zero raises `acquired` for exactly one cycle, in the cycle after the response, and `lock_held` is high from that cycle on. An acquire request while the lock is owned issues no memory request.
- R5: A test-and-set that returns non-zero is followed by exactly D cycles with no request, where D is the current backoff delay. A read comes in the cycle after those D cycles.
- R6: Successive failed test-and-sets within one acquisition wait 4, 8, 16, 32, 64, 128 and 256 cycles, and 256 for every later failure.
- R7: After a successful acquire, the first failed test-and-set of the next acquisition waits the minimum of 4 cycles again.
- R8: A release request while the lock is owned issues one write (op code 2'b10) with write data zero. When that write is answered, `released` pulses for one cycle, `lock_held` is low and the block is back in IDLE.
- R9: A release request outside HELD issues no write and does not change the acquisition in progress. `rel_err` goes high for exactly the next cycle.
- R10: At most one request is outstanding. After a request, `req_valid` stays low until the cycle after the response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_req | input | 1 | Acquire request, sampled in IDLE |
| rel_req | input | 1 | Release request, honoured only in HELD |
| req_valid | output | 1 | Request to the atomic memory unit, accepted the same cycle |
| req_op | output | 2 | 00 read, 01 test-and-set, 10 write |
| req_wdata | output | DW | Write data (always zero) |
| rsp_valid | input | 1 | Response strobe from the memory unit |
| rsp_data | input | DW | Returned lock word (old value for test-and-set) |
| acquired | output | 1 | One-cycle pulse on entry to HELD |
| released | output | 1 | One-cycle pulse when the release write completes |
| rel_err | output | 1 | One-cycle pulse for a release request outside HELD |
| lock_held | output | 1 | High while in HELD |

## Verification
Two things can land in the same cycle. One is a release request from the client; the other is the engine's own progress through polling, an atomic attempt or backoff. The bench pulses a release while the engine is still polling a busy lock word. It expects `rel_err` exactly one cycle later, no write at the memory port, and the acquisition to finish with the same number of reads and test-and-sets it would have issued without the release. A second coincidence is an acquire request while the lock is owned. The bench judges that case by the memory port staying silent.

// File: rtl/tts_pkg.sv
package tts_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_READ    = 3'd1,
        ST_TAS     = 3'd2,
        ST_BACKOFF = 3'd3,
        ST_HELD    = 3'd4,
        ST_RELEASE = 3'd5
    } tts_state_e;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_TAS   = 2'b01,
        OP_WRITE = 2'b10
    } tts_op_e;

endpackage

// File: rtl/tts_backoff.sv
module tts_backoff #(
    parameter int MIN_DELAY = 4,
    parameter int MAX_DELAY = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic clear,
    output logic expired
);
    localparam int CW = $clog2(MAX_DELAY + 1);
    localparam logic [CW-1:0] MIN_C  = CW'(MIN_DELAY);
    localparam logic [CW-1:0] MAX_C  = CW'(MAX_DELAY);
    localparam logic [CW-1:0] HALF_C = CW'(MAX_DELAY / 2);

    logic [CW-1:0] delay_q;
    logic [CW-1:0] cnt_q;

    function automatic logic [CW-1:0] grow(input logic [CW-1:0] d);
        if (d >= HALF_C) begin
            return MAX_C;
        end
        return d << 1;
    endfunction

    // Current delay: doubles per failure, capped, back to floor on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            delay_q <= MIN_C;
        end else if (clear) begin
            delay_q <= MIN_C;
        end else if (start) begin
            delay_q <= grow(delay_q);
        end
    end

    // Countdown: loaded with the current delay, one cycle per count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= delay_q;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == CW'(1));

endmodule

// File: rtl/tts_req_tracker.sv
module tts_req_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic issue,
    input  logic rsp_valid,
    output logic pending,
    output logic rsp_fire
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (issue) begin
            pend_q <= 1'b1;
        end else if (rsp_valid) begin
            pend_q <= 1'b0;
        end
    end

    assign pending  = pend_q;
    assign rsp_fire = pend_q && rsp_valid;

endmodule

// File: rtl/tts_req_mux.sv
module tts_req_mux
    import tts_pkg::*;
#(
    parameter int DW = 32
) (
    input  tts_state_e    state,
    input  logic          pending,
    output logic          req_valid,
    output logic [1:0]    req_op,
    output logic [DW-1:0] req_wdata
);
    always_comb begin
        req_valid = 1'b0;
        req_op    = OP_READ;
        req_wdata = '0;
        unique case (state)
            ST_READ: begin
                req_valid = !pending;
                req_op    = OP_READ;
            end
            ST_TAS: begin
                req_valid = !pending;
                req_op    = OP_TAS;
            end
            ST_RELEASE: begin
                req_valid = !pending;
                req_op    = OP_WRITE;
            end
            default: begin
                req_valid = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/tts_lock_engine.sv
module tts_lock_engine
    import tts_pkg::*;
#(
    parameter int DW        = 32,
    parameter int MIN_DELAY = 4,
    parameter int MAX_DELAY = 256
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acq_req,
    input  logic          rel_req,
    output logic          req_valid,
    output logic [1:0]    req_op,
    output logic [DW-1:0] req_wdata,
    input  logic          rsp_valid,
    input  logic [DW-1:0] rsp_data,
    output logic          acquired,
    output logic          released,
    output logic          rel_err,
    output logic          lock_held
);
    tts_state_e state_q, state_d;

    logic pending;
    logic rsp_fire;
    logic word_free;
    logic bo_start;
    logic bo_clear;
    logic bo_expired;

    logic acquired_q;
    logic released_q;
    logic rel_err_q;

    assign word_free = (rsp_data == '0);
    assign bo_start  = (state_q == ST_TAS) && rsp_fire && !word_free;
    assign bo_clear  = (state_q == ST_TAS) && rsp_fire &&  word_free;

    tts_req_tracker u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue     (req_valid),
        .rsp_valid (rsp_valid),
        .pending   (pending),
        .rsp_fire  (rsp_fire)
    );

    tts_req_mux #(.DW(DW)) u_mux (
        .state     (state_q),
        .pending   (pending),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_wdata (req_wdata)
    );

    tts_backoff #(
        .MIN_DELAY (MIN_DELAY),
        .MAX_DELAY (MAX_DELAY)
    ) u_backoff (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (bo_start),
        .clear   (bo_clear),
        .expired (bo_expired)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (acq_req) state_d = ST_READ;
            end
            ST_READ: begin
                if (rsp_fire && word_free) state_d = ST_TAS;
            end
            ST_TAS: begin
                if (rsp_fire) state_d = word_free ? ST_HELD : ST_BACKOFF;
            end
            ST_BACKOFF: begin
                if (bo_expired) state_d = ST_READ;
            end
            ST_HELD: begin
                if (rel_req) state_d = ST_RELEASE;
            end
            ST_RELEASE: begin
                if (rsp_fire) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Registered client outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acquired_q <= 1'b0;
            released_q <= 1'b0;
            rel_err_q  <= 1'b0;
        end else begin
            acquired_q <= bo_clear;
            released_q <= (state_q == ST_RELEASE) && rsp_fire;
            rel_err_q  <= rel_req && (state_q != ST_HELD);
        end
    end

    assign acquired  = acquired_q;
    assign released  = released_q;
    assign rel_err   = rel_err_q;
    assign lock_held = (state_q == ST_HELD);

endmodule

// File: rtl/tts_lock_engine_chk.sv
module tts_lock_engine_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          acq_req,
    input logic          rel_req,
    input logic          req_valid,
    input logic [1:0]    req_op,
    input logic [DW-1:0] req_wdata,
    input logic          rsp_valid,
    input logic [DW-1:0] rsp_data,
    input logic          acquired,
    input logic          released,
    input logic          rel_err,
    input logic          lock_held
);
    a_r10_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid);

    a_r4_acq_single: assert property (@(posedge clk) disable iff (!rst_n)
        acquired |=> !acquired);

    a_r4_acq_owns: assert property (@(posedge clk) disable iff (!rst_n)
        acquired |-> lock_held);

    a_r8_write_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b10) |-> (req_wdata == '0));

    a_r8_released_free: assert property (@(posedge clk) disable iff (!rst_n)
        released |-> !lock_held);

    a_r9_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rel_err |-> $past(rel_req && !lock_held));

    a_r9_err_single: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_err && !rel_req) |=> !rel_err);

endmodule

bind tts_lock_engine tts_lock_engine_chk #(.DW(DW)) u_chk (.*);

// File: tb/tts_lock_engine_test.sv
module tts_lock_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int NV = 5;
    localparam int VB [0:NV-1] = '{0, 3, 0, 2, 1};
    localparam int VF [0:NV-1] = '{0, 0, 2, 8, 1};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acq_req = 1'b0;
    logic          rel_req = 1'b0;
    logic          req_valid;
    logic [1:0]    req_op;
    logic [DW-1:0] req_wdata;
    logic          rsp_valid = 1'b0;
    logic [DW-1:0] rsp_data = '0;
    logic          acquired;
    logic          released;
    logic          rel_err;
    logic          lock_held;

    int n_checks = 0;
    int n_errors = 0;

    // memory model configuration (written by main only)
    int cfg_busy = 0;
    int cfg_fail = 0;
    int cfg_epoch = 0;

    // memory model statistics (written by model only)
    int n_read = 0;
    int n_tas = 0;
    int n_write = 0;
    int last_wdata = 0;
    int ng = 0;
    int gaps [0:63];

    tts_lock_engine #(.DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .acq_req(acq_req), .rel_req(rel_req),
        .req_valid(req_valid), .req_op(req_op), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .acquired(acquired), .released(released), .rel_err(rel_err),
        .lock_held(lock_held)
    );

    initial forever #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Atomic memory unit model: responds one cycle after each request.
    initial begin
        bit sched = 0;
        int sched_data = 0;
        int sched_op = 0;
        int cur_op = 0;
        int seen_epoch = -1;
        int reads_seen = 0;
        int tas_seen = 0;
        bit counting = 0;
        int cnt = 0;
        forever begin
            @(negedge clk);
            rsp_valid = sched;
            rsp_data  = DW'(sched_data);
            cur_op    = sched_op;
            sched     = 0;
            if (counting) begin
                if (req_valid) begin
                    if (ng < 64) gaps[ng] = cnt;
                    ng++;
                    counting = 0;
                end else begin
                    cnt++;
                end
            end
            if (rsp_valid && cur_op == 1 && rsp_data != '0) begin
                counting = 1;
                cnt = 0;
            end
            if (req_valid) begin
                if (seen_epoch != cfg_epoch) begin
                    seen_epoch = cfg_epoch;
                    reads_seen = 0;
                    tas_seen = 0;
                end
                sched = 1;
                sched_op = int'(req_op);
                case (req_op)
                    2'b00: begin
                        sched_data = (reads_seen < cfg_busy) ? 1 : 0;
                        reads_seen++;
                        n_read++;
                    end
                    2'b01: begin
                        sched_data = (tas_seen < cfg_fail) ? 1 : 0;
                        tas_seen++;
                        n_tas++;
                    end
                    default: begin
                        sched_data = 0;
                        last_wdata = int'(req_wdata);
                        n_write++;
                    end
                endcase
            end
        end
    end

    task automatic pulse_acq();
        @(negedge clk);
        acq_req = 1'b1;
        @(negedge clk);
        acq_req = 1'b0;
    endtask

    task automatic wait_acquired(output bit seen);
        seen = 0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (acquired) begin
                seen = 1;
                break;
            end
        end
    endtask

    task automatic do_release(input string tag);
        int w0;
        bit seen;
        w0 = n_write;
        rel_req = 1'b1;
        @(negedge clk);
        rel_req = 1'b0;
        seen = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (released) begin
                seen = 1;
                break;
            end
        end
        check(seen, {tag, " R8 released pulse"}, int'(seen), 1);
        check(n_write - w0 == 1, {tag, " R8 one write"}, n_write - w0, 1);
        check(last_wdata == 0, {tag, " R8 write data zero"}, last_wdata, 0);
        check(!lock_held, {tag, " R8 lock_held low"}, int'(lock_held), 0);
        @(negedge clk);
        check(!released, {tag, " R8 released one cycle"}, int'(released), 0);
        check(!req_valid, {tag, " R8 idle after release"}, int'(req_valid), 0);
    endtask

    // Watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        bit seen;
        int r0, t0, g0, d, quiet;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!req_valid && !acquired && !released && !rel_err && !lock_held,
              "R1 reset outputs low", int'(req_valid | acquired | released | rel_err | lock_held), 0);

        // R9: release in IDLE
        rel_req = 1'b1;
        @(negedge clk);
        rel_req = 1'b0;
        check(rel_err, "R9 rel_err in IDLE", int'(rel_err), 1);
        check(!req_valid && !lock_held, "R9 no request from stray release", int'(req_valid), 0);
        @(negedge clk);
        check(!rel_err, "R9 rel_err one cycle", int'(rel_err), 0);
        check(n_write == 0, "R9 no write in IDLE", n_write, 0);

        // Table of acquisition patterns: R2 R3 R4 R5 R6 R7
        for (int v = 0; v < NV; v++) begin
            cfg_busy = VB[v];
            cfg_fail = VF[v];
            cfg_epoch++;
            r0 = n_read; t0 = n_tas; g0 = ng;
            pulse_acq();
            wait_acquired(seen);
            check(seen, $sformatf("v%0d R4 acquired", v), int'(seen), 1);
            check(lock_held, $sformatf("v%0d R4 lock_held", v), int'(lock_held), 1);
            check(n_read - r0 == VB[v] + VF[v] + 1, $sformatf("v%0d R2 read count", v),
                  n_read - r0, VB[v] + VF[v] + 1);
            check(n_tas - t0 == VF[v] + 1, $sformatf("v%0d R3 tas count", v),
                  n_tas - t0, VF[v] + 1);
            check(ng - g0 == VF[v], $sformatf("v%0d R5 backoff count", v), ng - g0, VF[v]);
            d = 4;
            for (int k = 0; k < VF[v]; k++) begin
                check(gaps[g0 + k] == d, $sformatf("v%0d R6 R7 R5 gap %0d", v, k),
                      gaps[g0 + k], d);
                d = (d * 2 > 256) ? 256 : d * 2;
            end
            @(negedge clk);
            check(!acquired, $sformatf("v%0d R4 acquired one cycle", v), int'(acquired), 0);
            // R4: acquire request while held is ignored
            acq_req = 1'b1;
            @(negedge clk);
            acq_req = 1'b0;
            quiet = 0;
            for (int i = 0; i < 5; i++) begin
                @(negedge clk);
                if (req_valid) quiet++;
            end
            check(quiet == 0 && lock_held, $sformatf("v%0d R4 acq while held ignored", v), quiet, 0);
            do_release($sformatf("v%0d", v));
        end

        // R9: release during polling is ignored, acquisition unaffected
        cfg_busy = 4;
        cfg_fail = 1;
        cfg_epoch++;
        r0 = n_read; t0 = n_tas;
        pulse_acq();
        rel_req = 1'b1;
        @(negedge clk);
        rel_req = 1'b0;
        check(rel_err, "R9 rel_err while polling", int'(rel_err), 1);
        @(negedge clk);
        check(!rel_err, "R9 rel_err pulse width", int'(rel_err), 0);
        wait_acquired(seen);
        check(seen, "R9 acquisition completes", int'(seen), 1);
        check(n_read - r0 == 6, "R9 R2 reads unaffected", n_read - r0, 6);
        check(n_tas - t0 == 2, "R9 R3 tas unaffected", n_tas - t0, 2);
        check(n_write == NV, "R9 no write from stray release", n_write, NV);
        check(gaps[ng - 1] == 4, "R7 delay back to floor", gaps[ng - 1], 4);
        @(negedge clk);
        do_release("final");

        // R1: reset from HELD returns to idle state
        cfg_busy = 0; cfg_fail = 0; cfg_epoch++;
        pulse_acq();
        wait_acquired(seen);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!lock_held && !req_valid, "R1 reset clears ownership", int'(lock_held), 0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule